// File: doc/BRIEF.md
# Subcarrier and Frame Timer for an Infrared Remote Transmitter

This block creates the modulation timing for a biphase infrared remote control transmitter. A prescaler divides the oscillator clock by twelve to make a subcarrier. The subcarrier is high for a quarter or a third of each period, chosen by `duty_sel`. One counter chain is fed by that prescaler. It counts 64 subcarrier pulses to one bit time and 64 bit times to one frame, so a frame lasts 4096 pulses. The chain's position is available on `timer_state`, where the key scan and code store sequencing can decode it.

Upstream logic supplies the bit envelope. The block ANDs the envelope with the subcarrier to produce `mod_out`. While no key is active, a sleep request stops the whole chain and a wake request starts it again. Every restart begins at zero, so the first frame after wake-up is a full frame.

Top module: `carrier_ctl_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `running`, `carrier`, `bit_tick`, `frame_tick` and `mod_out` are 0 and `timer_state` is 0.
- R2: A cycle with `wake_req` high makes `running` 1 from the next cycle on. A cycle with `sleep_req` high and `wake_req` low makes `running` 0 from the next cycle on. When both are high, wake wins.
- R3: While `running` is 0, `timer_state` is 0. The first cycle with `running` 1 after a stop shows `timer_state` 0 and prescaler phase 0.
- R4: While running, the subcarrier period is 12 clocks, starting at phase 0. With `duty_sel` = 0, `carrier` is high on phases 0 to 2 and low on phases 3 to 11.
- R5: With `duty_sel` = 1, `carrier` is high on phases 0 to 3 and low on phases 4 to 11. `duty_sel` takes effect on the same cycle.
- R6: `timer_state[5:0]` holds the pulse count within the bit, from 0 to 63. It advances after phase 11. `bit_tick` is high for one cycle, on phase 11 of pulse 63, which is once every 768 running clocks.
- R7: `timer_state[11:6]` holds the bit count within the frame, from 0 to 63. It advances on `bit_tick` and wraps to 0. `frame_tick` is high only together with the `bit_tick` of bit 63, which is once every 49152 running clocks.
- R8: `mod_out` equals `envelope` AND `carrier`, so it is 0 whenever `running` is 0.
- R9: A `wake_req` while already running does not restart or disturb the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | 1 | Start request (key activity) |
| sleep_req | input | 1 | Stop request (idle keys) |
| duty_sel | input | 1 | 0: quarter duty, 1: third duty |
| envelope | input | 1 | Bit envelope to be modulated |
| running | output | 1 | Timer chain enabled |
| carrier | output | 1 | Subcarrier |
| bit_tick | output | 1 | Last clock of a bit time |
| frame_tick | output | 1 | Last clock of a frame |
| timer_state | output | 12 | {bit count, pulse count} |
| mod_out | output | 1 | Envelope gated by subcarrier |

## Verification
The assertions assume that `wake_req`, `sleep_req`, `duty_sel` and `envelope` are synchronous to `clk` and stable across each rising edge. The bench meets this by changing the inputs one nanosecond after each rising edge. The properties about stopping assume that wake has priority. To test that, the stimulus includes a cycle where sleep and wake are asserted together, and it also issues a wake while the timer is already running. The envelope follows a pseudo-random pattern, so the gating is tested against both carrier levels at both duty settings.

// File: rtl/carrier_timer_pkg.sv
package carrier_timer_pkg;

    localparam int unsigned CT_DIV_DEFAULT    = 12;
    localparam int unsigned CT_PULSES_DEFAULT = 64;
    localparam int unsigned CT_BITS_DEFAULT   = 64;

    typedef enum logic {
        DUTY_QUARTER = 1'b0,
        DUTY_THIRD   = 1'b1
    } duty_e;

    typedef struct packed {
        logic pulse_end;
        logic bit_end;
        logic frame_end;
    } tick_t;

    function automatic int unsigned high_phases(input duty_e d, input int unsigned div);
        return (d == DUTY_THIRD) ? div / 3 : div / 4;
    endfunction

endpackage

// File: rtl/ct_run_gate.sv
module ct_run_gate (
    input  logic clk,
    input  logic rst,
    input  logic wake_req,
    input  logic sleep_req,
    output logic run_q,
    output logic run_d
);
    always_comb begin
        if (wake_req)       run_d = 1'b1;
        else if (sleep_req) run_d = 1'b0;
        else                run_d = run_q;
    end

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= run_d;
    end
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler
    import carrier_timer_pkg::*;
#(
    parameter int unsigned DIV = CT_DIV_DEFAULT
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  run,
    input  duty_e duty,
    output logic  carrier,
    output logic  last
);
    localparam int unsigned PHW = $clog2(DIV);
    localparam logic [PHW-1:0] LAST_PH = PHW'(DIV - 1);

    logic [PHW-1:0] phase;
    logic [PHW-1:0] high_lim;

    always_comb begin
        high_lim = PHW'(high_phases(duty, DIV));
        carrier  = run && (phase < high_lim);
        last     = run && (phase == LAST_PH);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  phase <= '0;
        else if (last)   phase <= '0;
        else if (run)    phase <= phase + 1'b1;
    end
endmodule

// File: rtl/ct_seq_counter.sv
module ct_seq_counter #(
    parameter int unsigned N = 64,
    localparam int unsigned W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = W'(N - 1);

    assign wrap = adv && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (wrap)   cnt <= '0;
        else if (adv)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/carrier_ctl_timer.sv
module carrier_ctl_timer
    import carrier_timer_pkg::*;
#(
    parameter int unsigned DIV    = CT_DIV_DEFAULT,
    parameter int unsigned PULSES = CT_PULSES_DEFAULT,
    parameter int unsigned BITS   = CT_BITS_DEFAULT,
    localparam int unsigned PW    = $clog2(PULSES),
    localparam int unsigned BW    = $clog2(BITS),
    localparam int unsigned SW    = PW + BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wake_req,
    input  logic          sleep_req,
    input  logic          duty_sel,
    input  logic          envelope,
    output logic          running,
    output logic          carrier,
    output logic          bit_tick,
    output logic          frame_tick,
    output logic [SW-1:0] timer_state,
    output logic          mod_out
);
    logic          run_q, run_d, clr;
    logic          car;
    tick_t         tk;
    logic [PW-1:0] pulse_cnt;
    logic [BW-1:0] bit_cnt;
    duty_e         duty;

    assign duty = duty_e'(duty_sel);
    assign clr  = !run_q || !run_d;

    ct_run_gate u_gate (
        .clk(clk), .rst(rst), .wake_req(wake_req), .sleep_req(sleep_req),
        .run_q(run_q), .run_d(run_d)
    );

    ct_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst(rst), .clr(clr), .run(run_q), .duty(duty),
        .carrier(car), .last(tk.pulse_end)
    );

    ct_seq_counter #(.N(PULSES)) u_pulse (
        .clk(clk), .rst(rst), .clr(clr), .adv(tk.pulse_end),
        .cnt(pulse_cnt), .wrap(tk.bit_end)
    );

    ct_seq_counter #(.N(BITS)) u_bit (
        .clk(clk), .rst(rst), .clr(clr), .adv(tk.bit_end),
        .cnt(bit_cnt), .wrap(tk.frame_end)
    );

    assign running     = run_q;
    assign carrier     = car;
    assign bit_tick    = tk.bit_end;
    assign frame_tick  = tk.frame_end;
    assign timer_state = {bit_cnt, pulse_cnt};
    assign mod_out     = envelope && car;
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
    parameter int unsigned PW = 6,
    parameter int unsigned SW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          wake_req,
    input logic          sleep_req,
    input logic          envelope,
    input logic          running,
    input logic          carrier,
    input logic          bit_tick,
    input logic          frame_tick,
    input logic [SW-1:0] timer_state,
    input logic          mod_out
);
    assert_wake_R2: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> running);

    assert_sleep_R2: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && !wake_req) |=> !running);

    assert_stopped_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !running |-> (timer_state == '0));

    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> (timer_state == '0) && carrier);

    assert_bit_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> (timer_state[PW-1:0] == '0));

    assert_frame_in_bit_R7: assert property (@(posedge clk) disable iff (rst)
        frame_tick |-> bit_tick);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !running |-> !carrier && !mod_out && !bit_tick);

    assert_mod_gate_R8: assert property (@(posedge clk) disable iff (rst)
        mod_out |-> (envelope && carrier));
endmodule

bind carrier_ctl_timer ct_checker #(.PW(PW), .SW(SW)) u_chk (
    .clk(clk), .rst(rst), .wake_req(wake_req), .sleep_req(sleep_req),
    .envelope(envelope), .running(running), .carrier(carrier),
    .bit_tick(bit_tick), .frame_tick(frame_tick),
    .timer_state(timer_state), .mod_out(mod_out)
);

// File: tb/tb_carrier_ctl_timer.sv
`timescale 1ns/1ps
module tb_carrier_ctl_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wake_req = 1'b0, sleep_req = 1'b0, duty_sel = 1'b0, envelope = 1'b0;
    logic        running, carrier, bit_tick, frame_tick, mod_out;
    logic [11:0] timer_state;

    int vectors = 0;
    int fails   = 0;
    bit chk_on  = 1'b0;
    bit done    = 1'b0;

    // reference model state
    int m_run = 0, m_ph = 0, m_pu = 0, m_bt = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    carrier_ctl_timer dut (
        .clk(clk), .rst(rst), .wake_req(wake_req), .sleep_req(sleep_req),
        .duty_sel(duty_sel), .envelope(envelope), .running(running),
        .carrier(carrier), .bit_tick(bit_tick), .frame_tick(frame_tick),
        .timer_state(timer_state), .mod_out(mod_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        int nrun;
        if (rst) begin
            m_run = 0; m_ph = 0; m_pu = 0; m_bt = 0;
        end else begin
            nrun = wake_req ? 1 : (sleep_req ? 0 : m_run);
            if (m_run == 1 && nrun == 1) begin
                m_ph++;
                if (m_ph == 12) begin
                    m_ph = 0; m_pu++;
                    if (m_pu == 64) begin
                        m_pu = 0;
                        m_bt = (m_bt + 1) % 64;
                    end
                end
            end else begin
                m_ph = 0; m_pu = 0; m_bt = 0;
            end
            m_run = nrun;
        end
    end

    // envelope pattern
    always @(posedge clk) begin
        #1;
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        envelope <= lfsr[0];
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (chk_on) begin
            int hi, e_car, e_bt, e_fr;
            hi    = duty_sel ? 4 : 3;
            e_car = (m_run == 1 && m_ph < hi) ? 1 : 0;
            e_bt  = (m_run == 1 && m_ph == 11 && m_pu == 63) ? 1 : 0;
            e_fr  = (e_bt == 1 && m_bt == 63) ? 1 : 0;
            chk("R2 running", running, m_run);
            chk(duty_sel ? "R5 carrier" : "R4 carrier", carrier, e_car);
            chk("R6 bit_tick", bit_tick, e_bt);
            chk("R6 pulse count", timer_state[5:0], m_pu);
            chk("R7 bit count", timer_state[11:6], m_bt);
            chk("R7 frame_tick", frame_tick, e_fr);
            chk("R8 mod_out", mod_out, (envelope && e_car) ? 1 : 0);
            if (m_run == 0) chk("R3 stopped state", timer_state, 0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        step(4);
        @(negedge clk);
        chk("R1 reset outputs", {running, carrier, bit_tick, frame_tick, mod_out}, 0);
        chk("R1 reset timer", timer_state, 0);
        step(1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle after reset", {running, carrier, mod_out}, 0);
        chk_on = 1'b1;
        step(20);                                  // idle: R3, R8
        wake_req = 1'b1; step(1); wake_req = 1'b0; // start
        step(3000);
        duty_sel = 1'b1; step(3000);               // R5
        wake_req = 1'b1; step(1); wake_req = 1'b0; // R9
        @(negedge clk);
        chk("R9 no restart on wake", (timer_state != 0) ? 1 : 0, 1);
        chk("R9 timer continues", timer_state, m_bt * 64 + m_pu);
        duty_sel = 1'b0;
        step(46000);                               // past a full frame: R7
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
        step(30);
        wake_req = 1'b1; step(1); wake_req = 1'b0; // restart: R3
        step(1000);
        wake_req = 1'b1; sleep_req = 1'b1; step(1);
        wake_req = 1'b0; sleep_req = 1'b0;         // wake priority: R2
        step(10);
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
        step(10);
        chk_on = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule